// File: doc/BRIEF.md
# Polled RS-485 Request/Response Transaction Controller

This block carries out a single polled exchange with a remote board over a half-duplex RS-485 byte link. When started, it takes a body of 26 bytes and wraps it into a fixed 28-byte frame. The frame starts with a delimiter byte and ends with a CRC-8 check byte. The block shifts the frame out serially, enabling the line driver only while it talks. It then listens for a 28-byte reply of the same shape.

A reply is accepted only if it is complete and valid. The block counts an attempt as failed in three cases: the reply does not finish in time, its first byte is wrong, or its check byte is wrong. It then resends the same request, up to a fixed number of retries. At the end it raises a one-cycle completion pulse. With the pulse it reports a success flag, the number of unsuccessful calls and the 28 bytes received in the last attempt. A higher layer uses these to decide what to do with the remote board.

Top module: `rs485_xact_ctrl`

## Requirements
- R1: During and right after reset, rs485_de and busy are low, done is low and rs485_txd is high.
- R2: Each request frame has 28 bytes: byte 0 is 0x40, byte k (1..26) is tx_body[8(k-1)+7 : 8(k-1)], and byte 27 is the CRC-8 of bytes 0..26. The CRC uses polynomial 0x07 and preset 0xFF, processes each byte MSB first, and has no reflection and no final XOR.
- R3: Every byte goes out as one low start bit, eight data bits LSB first and one high stop bit, each bit lasting CLKS_PER_BIT clocks. The default of 200 clocks gives 250 kbaud from a 50 MHz clock. rs485_txd is high whenever the driver is disabled.
- R4: rs485_de is high before the first start bit of a request. It stays high until one bit time (within two clocks) after the last stop bit, and is low at all other times.
- R5: A reply is accepted when 28 bytes arrive with correct framing, byte 0 equal to 0x40 and byte 27 equal to the CRC-8 (as in R2) of bytes 0..26. On acceptance, done pulses with ok high, and rx_frame holds reply byte k at bits [8k+7:8k].
- R6: If no complete reply arrives within TIMEOUT_CLKS clocks after rs485_de falls, the attempt fails and the request is sent again. The default is 100000 clocks, which is 2 ms at 50 MHz.
- R7: A complete reply with a wrong first byte, a wrong check byte or a missing stop bit counts as a failed attempt and causes a resend.
- R8: There are at most MAX_RETRIES+1 attempts, 3 by default. After the last one fails, done pulses with ok low and fail_count equal to the number of attempts. rx_frame then holds the bytes of the last attempt, with zeros where none arrived.
- R9: On success, fail_count equals the number of failed attempts that came before the good reply.
- R10: busy rises in the cycle after an accepted start and stays high through the single-cycle done pulse. A start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| tx_body | input | 208 | Request body, byte j at bits [8j+7:8j] |
| rs485_rxd | input | 1 | Receive line from the transceiver |
| rs485_txd | output | 1 | Transmit line to the transceiver |
| rs485_de | output | 1 | Driver enable for the transceiver |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last transaction succeeded (valid with done) |
| fail_count | output | 2 | Unsuccessful calls of the last transaction |
| rx_frame | output | 224 | Bytes received in the last attempt |

## Verification
The bench plays the remote board: it decodes the transmit line bit by bit, and it answers each request with a good reply, a corrupted reply or no reply at all. It recomputes the CRC of every request with its own bit-serial formulation. A checksum that covered the wrong bytes, or used the wrong preset, would therefore show up as a mismatched byte 27. Retry sequences mixing a timeout, a bad delimiter and a bad check byte show the following faults. A design that accepted corrupted replies would report ok with a fail_count that is too low. A design that miscounted attempts would send the wrong number of request frames or report the wrong fail_count on failure. The bench also measures the gap between the last stop bit and the fall of the driver enable. Finally, it pulses start in the middle of an exchange, which would reveal a controller that restarts or adds a frame.

// File: rtl/rs485_xact_pkg.sv
package rs485_xact_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_DRAIN,
    ST_GUARD,
    ST_WAIT,
    ST_DONE
  } xact_state_t;

  // One byte through the CRC register: xor the byte in, then shift eight times.
  function automatic logic [7:0] crc8_update(input logic [7:0] crc,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

  // Bits needed by a counter that runs from 0 to n-1.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rs485_crc8_acc.sv
module rs485_crc8_acc
  import rs485_xact_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic [7:0] data,
  output logic [7:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= INIT;
    end else if (clear) begin
      crc <= INIT;
    end else if (en) begin
      crc <= crc8_update(crc, data, POLY);
    end
  end

endmodule

// File: rtl/rs485_byte_tx.sv
module rs485_byte_tx
  import rs485_xact_pkg::*;
#(
  parameter int CLKS_PER_BIT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       ready,
  output logic       txd
);

  localparam int CW = cnt_width(CLKS_PER_BIT);
  localparam int SYM_BITS = 10;

  logic [SYM_BITS-1:0] shreg;
  logic [CW-1:0]       cnt;
  logic [3:0]          bitn;
  logic                bit_end;

  assign bit_end = (cnt == CW'(CLKS_PER_BIT - 1));
  assign txd     = ready ? 1'b1 : shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      shreg <= '1;
      cnt   <= '0;
      bitn  <= '0;
    end else if (ready) begin
      if (load) begin
        shreg <= {1'b1, data, 1'b0};
        ready <= 1'b0;
        cnt   <= '0;
        bitn  <= '0;
      end
    end else if (bit_end) begin
      cnt   <= '0;
      shreg <= {1'b1, shreg[SYM_BITS-1:1]};
      if (bitn == 4'(SYM_BITS - 1)) begin
        ready <= 1'b1;
      end else begin
        bitn <= bitn + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rs485_byte_rx.sv
module rs485_byte_rx
  import rs485_xact_pkg::*;
#(
  parameter int CLKS_PER_BIT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rxd,
  output logic       valid,
  output logic [7:0] data,
  output logic       frame_err
);

  localparam int CW   = cnt_width(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_phase_t;

  rx_phase_t     phase;
  logic          rxd_m, rxd_s;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          full_bit;
  logic          half_bit;

  assign full_bit = (cnt == CW'(CLKS_PER_BIT - 1));
  assign half_bit = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= RX_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
      valid     <= 1'b0;
      data      <= '0;
      frame_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!en) begin
        phase <= RX_IDLE;
      end else begin
        unique case (phase)
          RX_IDLE: begin
            if (!rxd_s) begin
              phase <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (half_bit) begin
              cnt   <= '0;
              bitn  <= '0;
              phase <= rxd_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (full_bit) begin
              cnt <= '0;
              sh  <= {rxd_s, sh[7:1]};
              if (bitn == 3'd7) begin
                phase <= RX_STOP;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (full_bit) begin
              valid     <= 1'b1;
              data      <= sh;
              frame_err <= !rxd_s;
              phase     <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rs485_xact_ctrl.sv
module rs485_xact_ctrl
  import rs485_xact_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 200,
  parameter int         FRAME_BYTES  = 28,
  parameter int         TIMEOUT_CLKS = 100000,
  parameter int         MAX_RETRIES  = 2,
  parameter logic [7:0] DELIM        = 8'h40,
  parameter logic [7:0] CRC_POLY     = 8'h07,
  parameter logic [7:0] CRC_INIT     = 8'hFF
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [(FRAME_BYTES-2)*8-1:0]          tx_body,
  input  logic                                  rs485_rxd,
  output logic                                  rs485_txd,
  output logic                                  rs485_de,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  ok,
  output logic [$clog2(MAX_RETRIES+2)-1:0]      fail_count,
  output logic [FRAME_BYTES*8-1:0]              rx_frame
);

  localparam int BODY_BYTES = FRAME_BYTES - 2;
  localparam int LAST       = FRAME_BYTES - 1;
  localparam int ATTEMPTS   = MAX_RETRIES + 1;
  localparam int AW         = $clog2(MAX_RETRIES + 2);
  localparam int IW         = cnt_width(FRAME_BYTES);
  localparam int TW         = cnt_width(TIMEOUT_CLKS);
  localparam int GW         = cnt_width(CLKS_PER_BIT);

  xact_state_t                 state;
  logic [BODY_BYTES*8-1:0]     body_q;
  logic [IW-1:0]               idx;
  logic [IW-1:0]               rcnt;
  logic [TW-1:0]               tmo;
  logic [GW-1:0]               guard;
  logic [AW-1:0]               fails;
  logic                        reply_bad;
  logic [FRAME_BYTES*8-1:0]    rx_frame_q;

  logic       tx_ready, tx_load;
  logic [7:0] tx_byte, body_byte, crc_tx;
  logic       rx_valid, rx_frame_err;
  logic [7:0] rx_data, crc_rx;

  // Named event wires, also watched by the bound checker.
  logic bad_now;
  logic reply_done;
  logic reply_good;
  logic tmo_hit;
  logic attempt_fail;
  logic last_attempt;

  // ---------------------------------------------------------------- transmit
  always_comb begin
    body_byte = '0;
    for (int k = 0; k < BODY_BYTES; k++) begin
      if (idx == IW'(k + 1)) body_byte = body_q[8*k +: 8];
    end
  end

  always_comb begin
    if (idx == '0)                tx_byte = DELIM;
    else if (idx == IW'(LAST))    tx_byte = crc_tx;
    else                          tx_byte = body_byte;
  end

  assign tx_load = (state == ST_SEND) && tx_ready;

  rs485_byte_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tx_load),
    .data  (tx_byte),
    .ready (tx_ready),
    .txd   (rs485_txd)
  );

  rs485_crc8_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_SEND),
    .en    (tx_load && (idx != IW'(LAST))),
    .data  (tx_byte),
    .crc   (crc_tx)
  );

  // ----------------------------------------------------------------- receive
  rs485_byte_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state == ST_WAIT),
    .rxd       (rs485_rxd),
    .valid     (rx_valid),
    .data      (rx_data),
    .frame_err (rx_frame_err)
  );

  rs485_crc8_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_WAIT),
    .en    (rx_valid && (rcnt != IW'(LAST))),
    .data  (rx_data),
    .crc   (crc_rx)
  );

  assign bad_now      = rx_frame_err
                      || ((rcnt == '0) && (rx_data != DELIM))
                      || ((rcnt == IW'(LAST)) && (rx_data != crc_rx));
  assign reply_done   = (state == ST_WAIT) && rx_valid && (rcnt == IW'(LAST));
  assign reply_good   = reply_done && !reply_bad && !bad_now;
  assign tmo_hit      = (state == ST_WAIT) && (tmo == TW'(TIMEOUT_CLKS - 1)) && !reply_done;
  assign attempt_fail = (reply_done && !reply_good) || tmo_hit;
  assign last_attempt = (fails == AW'(ATTEMPTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_frame_q <= '0;
    end else if (state == ST_GUARD) begin
      rx_frame_q <= '0;
    end else if ((state == ST_WAIT) && rx_valid) begin
      for (int k = 0; k < FRAME_BYTES; k++) begin
        if (rcnt == IW'(k)) rx_frame_q[8*k +: 8] <= rx_data;
      end
    end
  end

  // --------------------------------------------------------------- sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      body_q     <= '0;
      idx        <= '0;
      rcnt       <= '0;
      tmo        <= '0;
      guard      <= '0;
      fails      <= '0;
      reply_bad  <= 1'b0;
      ok         <= 1'b0;
      fail_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            body_q <= tx_body;
            fails  <= '0;
            idx    <= '0;
            state  <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_load) begin
            if (idx == IW'(LAST)) state <= ST_DRAIN;
            else                  idx   <= idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (tx_ready) begin
            guard <= '0;
            state <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (guard == GW'(CLKS_PER_BIT - 1)) begin
            tmo       <= '0;
            rcnt      <= '0;
            reply_bad <= 1'b0;
            state     <= ST_WAIT;
          end else begin
            guard <= guard + 1'b1;
          end
        end
        ST_WAIT: begin
          tmo <= tmo + 1'b1;
          if (rx_valid) begin
            rcnt      <= rcnt + 1'b1;
            reply_bad <= reply_bad | bad_now;
          end
          if (reply_good) begin
            ok         <= 1'b1;
            fail_count <= fails;
            state      <= ST_DONE;
          end else if (attempt_fail) begin
            fails <= fails + 1'b1;
            if (last_attempt) begin
              ok         <= 1'b0;
              fail_count <= fails + 1'b1;
              state      <= ST_DONE;
            end else begin
              idx   <= '0;
              state <= ST_SEND;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rs485_de = (state == ST_SEND) || (state == ST_DRAIN) || (state == ST_GUARD);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign rx_frame = rx_frame_q;

endmodule

// File: rtl/rs485_xact_chk.sv
module rs485_xact_chk #(
  parameter int ATTEMPTS = 3,
  parameter int FCW      = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           ok,
  input logic [FCW-1:0] fail_count,
  input logic           rs485_de,
  input logic           rs485_txd,
  input logic           attempt_fail,
  input logic           last_attempt,
  input logic           tmo_hit
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rs485_de && rs485_txd));

  assert_txd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rs485_de |-> rs485_txd);

  assert_de_off_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rs485_de);

  assert_ok_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (fail_count < FCW'(ATTEMPTS)));

  assert_timeout_listening_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |-> !rs485_de);

  assert_resend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_fail && !last_attempt) |=> rs485_de);

  assert_final_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_fail && last_attempt) |=> (done && !ok && (fail_count == FCW'(ATTEMPTS))));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

endmodule

bind rs485_xact_ctrl rs485_xact_chk #(
  .ATTEMPTS (MAX_RETRIES + 1),
  .FCW      ($clog2(MAX_RETRIES + 2))
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .ok           (ok),
  .fail_count   (fail_count),
  .rs485_de     (rs485_de),
  .rs485_txd    (rs485_txd),
  .attempt_fail (attempt_fail),
  .last_attempt (last_attempt),
  .tmo_hit      (tmo_hit)
);

// File: tb/tb_rs485_xact_ctrl.sv
`timescale 1ns/1ps
module tb_rs485_xact_ctrl;

  localparam int B      = 8;
  localparam int TMO    = 3000;
  localparam int NB     = 28;
  localparam int BODY   = NB - 2;
  localparam int BIT_NS = B * 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [BODY*8-1:0] tx_body = '0;
  logic              rxd = 1'b1;
  logic              txd, de, busy, done, ok;
  logic [1:0]        fail_count;
  logic [NB*8-1:0]   rx_frame;

  always #5 clk = ~clk;

  rs485_xact_ctrl #(.CLKS_PER_BIT(B), .FRAME_BYTES(NB), .TIMEOUT_CLKS(TMO), .MAX_RETRIES(2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_body(tx_body), .rs485_rxd(rxd),
    .rs485_txd(txd), .rs485_de(de), .busy(busy), .done(done), .ok(ok),
    .fail_count(fail_count), .rx_frame(rx_frame)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] req_b [0:127];
  int  req_n = 0;
  int  tx_stop_bad = 0;
  int  de_bad = 0;
  int  de_fall_n = 0;
  int  done_n = 0;
  time last_stop_end = 0;
  logic            cap_ok;
  logic [1:0]      cap_fc;
  logic [NB*8-1:0] cap_rx;
  logic            cap_busy;
  logic [NB*8-1:0] rep_packed = '0;

  task automatic check(input string what, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Bit-serial CRC over the first 27 bytes of a packed frame.
  function automatic logic [7:0] ref_crc(input logic [NB*8-1:0] v);
    logic [7:0] c;
    logic fb;
    c = 8'hFF;
    for (int k = 0; k < NB - 1; k++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[7] ^ v[8*k + b];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  // Line monitor: decodes the transmit line at the bench's own bit time.
  initial begin
    logic [7:0] b;
    time t0;
    forever begin
      @(negedge txd);
      t0 = $time;
      if (de !== 1'b1) de_bad++;
      #(BIT_NS/2 + 3);
      if (txd === 1'b0) begin
        for (int i = 0; i < 8; i++) begin
          #(BIT_NS);
          b[i] = txd;
        end
        #(BIT_NS);
        if (txd !== 1'b1) tx_stop_bad++;
        if (req_n < 128) req_b[req_n] = b;
        req_n++;
        last_stop_end = t0 + 10 * BIT_NS;
      end
    end
  end

  initial begin
    time gap;
    forever begin
      @(negedge de);
      if (rst_n) begin
        de_fall_n++;
        gap = $time - last_stop_end;
        if (gap < BIT_NS || gap > BIT_NS + 20) de_bad++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_n++;
      cap_ok   = ok;
      cap_fc   = fail_count;
      cap_rx   = rx_frame;
      cap_busy = busy;
    end
  end

  task automatic drive_byte(input logic [7:0] v);
    rxd = 1'b0;
    #(BIT_NS);
    for (int i = 0; i < 8; i++) begin
      rxd = v[i];
      #(BIT_NS);
    end
    rxd = 1'b1;
    #(BIT_NS);
  endtask

  // kind 1 good, 2 bad delimiter, 3 bad check byte
  task automatic send_reply(input logic [1:0] kind, input logic [7:0] seed);
    logic [NB*8-1:0] f;
    logic [7:0] c;
    f = '0;
    f[7:0] = (kind == 2'd2) ? 8'h41 : 8'h40;
    for (int k = 1; k < NB - 1; k++) f[8*k +: 8] = seed + 8'(k * 13);
    c = ref_crc(f);
    f[8*(NB-1) +: 8] = (kind == 2'd3) ? (c ^ 8'h5A) : c;
    rep_packed = f;
    #25;
    for (int k = 0; k < NB; k++) drive_byte(f[8*k +: 8]);
  endtask

  task automatic run_case(input string tag, input logic [7:0] seed,
                          input logic [1:0] k0, input logic [1:0] k1, input logic [1:0] k2,
                          input int exp_att, input logic exp_ok, input logic [1:0] exp_fc,
                          input bit poke);
    logic [1:0] kinds [3];
    logic [NB*8-1:0] exp_req;
    int handled;
    int bad;
    int req_seen;
    kinds = '{k0, k1, k2};
    for (int j = 0; j < BODY; j++) tx_body[8*j +: 8] = seed ^ 8'(j * 29);
    exp_req = '0;
    exp_req[7:0] = 8'h40;
    exp_req[8 +: BODY*8] = tx_body;
    exp_req[8*(NB-1) +: 8] = ref_crc(exp_req);
    req_n = 0; done_n = 0; de_fall_n = 0; de_bad = 0; tx_stop_bad = 0;
    handled = 0; rep_packed = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check({tag, " R10 busy after start"}, 256'(busy), 256'(1));
    forever begin
      wait (de_fall_n > handled || done_n > 0);
      if (done_n > 0) break;
      handled++;
      if (poke && handled == 1) begin
        @(negedge clk); start = 1'b1; tx_body = ~tx_body;
        @(negedge clk); start = 1'b0; tx_body = ~tx_body;
      end
      if (handled <= 3 && kinds[handled-1] != 2'd0) send_reply(kinds[handled-1], seed + 8'h11);
    end
    repeat (3) @(negedge clk);
    req_seen = req_n;
    check({tag, " R6 R7 R8 request frames sent"}, 256'(req_seen), 256'(exp_att * NB));
    bad = 0;
    for (int a = 0; a < exp_att; a++)
      for (int k = 0; k < NB; k++)
        if (req_b[a*NB + k] !== exp_req[8*k +: 8]) bad++;
    check({tag, " R2 request bytes wrong"}, 256'(bad), 256'(0));
    check({tag, " R3 stop bits bad"}, 256'(tx_stop_bad), 256'(0));
    check({tag, " R4 driver enable timing"}, 256'(de_bad), 256'(0));
    check({tag, " R10 done pulses"}, 256'(done_n), 256'(1));
    check({tag, " R10 busy with done"}, 256'(cap_busy), 256'(1));
    check({tag, " R10 busy after done"}, 256'(busy), 256'(0));
    check({tag, " R5 R8 ok"}, 256'(cap_ok), 256'(exp_ok));
    check({tag, " R8 R9 fail_count"}, 256'(cap_fc), 256'(exp_fc));
    check({tag, " R5 R8 rx_frame"}, 256'(cap_rx), 256'(rep_packed));
    if (poke) begin
      repeat (60) @(negedge clk);
      check({tag, " R10 ignored start left idle"}, 256'(busy), 256'(0));
      check({tag, " R10 ignored start added no frame"}, 256'(req_n), 256'(exp_att * NB));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R10: actual no completion expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic test_reset;
    repeat (3) @(negedge clk);
    check("R1 de in reset", 256'(de), 256'(0));
    check("R1 txd in reset", 256'(txd), 256'(1));
    check("R1 busy in reset", 256'(busy), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after reset", 256'(done), 256'(0));
    check("R1 de after reset", 256'(de), 256'(0));
  endtask

  initial begin
    test_reset();
    run_case("good_first",      8'h3C, 2'd1, 2'd0, 2'd0, 1, 1'b1, 2'd0, 1'b0);
    run_case("timeout_then_ok", 8'hA5, 2'd0, 2'd1, 2'd0, 2, 1'b1, 2'd1, 1'b0);
    run_case("baddelim_then_ok",8'h07, 2'd2, 2'd1, 2'd0, 2, 1'b1, 2'd1, 1'b0);
    run_case("crc_delim_ok",    8'hF0, 2'd3, 2'd2, 2'd1, 3, 1'b1, 2'd2, 1'b0);
    run_case("badcrc_x3",       8'h5E, 2'd3, 2'd3, 2'd3, 3, 1'b0, 2'd3, 1'b0);
    run_case("timeout_x3",      8'h81, 2'd0, 2'd0, 2'd0, 3, 1'b0, 2'd3, 1'b0);
    run_case("start_while_busy",8'h19, 2'd1, 2'd0, 2'd0, 1, 1'b1, 2'd0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule